// File: doc/BRIEF.md
# Serial audio FIFO control unit

This block is the buffering and control core of a serial audio port. A transmit FIFO collects samples written by the processor or by a DMA engine. A receive FIFO collects samples captured from the link. A control register holds a link enable and two 4-bit watermark values, one for each direction. From the FIFO levels the block raises a transmit DMA request, a receive DMA request and one interrupt line.

The serial shifter and the bit clock generator sit outside the block. They present one strobe per audio frame, together with the captured sample. On each strobe the block returns the next sample to send, advances its frame counter and toggles a frame sync output. When the enable is cleared, the link is frozen: the receive side is flushed and held empty, the transmit FIFO keeps its contents, requests and the interrupt are withdrawn, and data reads return zero.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: Control register (address 0): bit 0 is the enable, bits 11:8 are the transmit watermark, and bits 15:12 are the receive watermark. All other bits read as zero. After reset it reads 0x0000_7700.
- R2: A write to the data register (address 1) pushes the write data into the transmit FIFO, which holds 16 entries. A write while the FIFO holds 16 entries is discarded. This applies whether or not the link is enabled.
- R3: On a frame strobe while enabled, the oldest transmit entry is moved to `sample_out`, or zero if the FIFO is empty. In the same cycle `sample_in` is appended to the receive FIFO. Both FIFOs keep first-in first-out order.
- R4: A frame strobe while enabled that finds the receive FIFO holding 16 entries drops the sample. It also sets a sticky overrun flag (status bit 22), which stays set while enabled.
- R5: `dma_rx_req` is 1 exactly when enabled and the receive level is at least the receive watermark + 1. `dma_tx_req` is 1 exactly when enabled and the transmit level is below the transmit watermark + 1.
- R6: `irq` is 1 exactly when enabled and at least one of these holds: the transmit level is below its mark, the receive level has reached its mark, or the overrun flag is set.
- R7: `frame_sync` toggles once for each frame strobe seen while enabled, and holds its value while disabled. `frame_count` counts strobes while enabled and is held at zero while disabled.
- R8: While disabled, the receive FIFO is emptied and kept empty, and the overrun flag is cleared. The transmit FIFO level and contents are left unchanged, and frame strobes do not change `sample_out`.
- R9: A read of the data register while enabled returns the oldest receive entry and removes it, or returns zero if the FIFO is empty. While disabled, the read returns zero and removes nothing.
- R10: Status register (address 2) layout:
  - bits 7:0 hold the transmit level and bits 15:8 the receive level;
  - bit 16 is transmit empty, bit 17 is transmit full and bit 18 is transmit below mark;
  - bit 19 is receive empty, bit 20 is receive full and bit 21 is receive at or above mark;
  - bit 22 is overrun;
  - all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| frame_strobe | input | 1 | One pulse per audio frame from the shifter |
| sample_in | input | 32 | Sample captured from the link |
| sample_out | output | 32 | Sample handed to the link |
| frame_sync | output | 1 | Frame sync, toggles per frame |
| frame_count | output | 8 | Frames since the link was enabled |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the rules that disabling imposes:
- no request and no interrupt while disabled;
- a still frame sync while disabled;
- an emptied receive FIFO and a transmit level that does not move;
- zero read data while disabled.

They also check that the levels never pass the depth, that an overrun stays set while enabled, and that each request follows its watermark. The directed scenarios are needed for what depends on data and ordering: which word leaves on each frame, the sample kept when the receive FIFO overflows, the exact boundary cycle at each watermark, and recovery after the link is enabled again.

// File: rtl/afc_pkg.sv
`timescale 1ns/1ps
package afc_pkg;
  localparam int DATA_W_DEF = 32;
  localparam int DEPTH_DEF  = 16;
  localparam int MARK_W     = 4;
  localparam logic [MARK_W-1:0] MARK_RESET = 4'd7;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  // Transmit side wants more data: level below programmed mark plus one.
  function automatic logic below_mark(input logic [7:0] lvl, input logic [7:0] mark);
    return lvl < (mark + 8'd1);
  endfunction

  // Receive side has enough data: level at or above programmed mark plus one.
  function automatic logic reached_mark(input logic [7:0] lvl, input logic [7:0] mark);
    return lvl >= (mark + 8'd1);
  endfunction
endpackage

// File: rtl/afc_fifo.sv
`timescale 1ns/1ps
module afc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/afc_ctrl_reg.sv
`timescale 1ns/1ps
module afc_ctrl_reg
  import afc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wd_en,
  input  logic [MARK_W-1:0] wd_tx_mark,
  input  logic [MARK_W-1:0] wd_rx_mark,
  output logic              en,
  output logic [MARK_W-1:0] tx_mark,
  output logic [MARK_W-1:0] rx_mark
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      tx_mark <= MARK_RESET;
      rx_mark <= MARK_RESET;
    end else if (wr) begin
      en      <= wd_en;
      tx_mark <= wd_tx_mark;
      rx_mark <= wd_rx_mark;
    end
  end
endmodule

// File: rtl/afc_link.sv
`timescale 1ns/1ps
module afc_link #(
  parameter int W      = 32,
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strobe,
  input  logic [W-1:0]      tx_head,
  input  logic              tx_empty,
  input  logic              rx_full,
  output logic              tx_pop,
  output logic              rx_push,
  output logic              rx_drop,
  output logic [W-1:0]      sample_out,
  output logic              frame_sync,
  output logic [FCNT_W-1:0] frame_count,
  output logic              overrun
);
  logic frame_ev;

  assign frame_ev = en && strobe;
  assign tx_pop   = frame_ev && !tx_empty;
  assign rx_push  = frame_ev && !rx_full;
  assign rx_drop  = frame_ev && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out  <= '0;
      frame_sync  <= 1'b0;
      frame_count <= '0;
      overrun     <= 1'b0;
    end else begin
      if (frame_ev) begin
        sample_out <= tx_empty ? '0 : tx_head;
        frame_sync <= ~frame_sync;
      end
      if (!en)           frame_count <= '0;
      else if (frame_ev) frame_count <= frame_count + FCNT_W'(1);
      if (!en)           overrun <= 1'b0;
      else if (rx_drop)  overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_fifo_ctrl.sv
`timescale 1ns/1ps
module audio_fifo_ctrl
  import afc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_strobe,
  input  logic [DATA_W-1:0] sample_in,
  output logic [DATA_W-1:0] sample_out,
  output logic              frame_sync,
  output logic [FCNT_W-1:0] frame_count,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              en;
  logic [MARK_W-1:0] tx_mark, rx_mark;
  logic              ctrl_wr, tx_push, tx_pop, rx_push, rx_pop, rx_drop, rx_flush;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty, overrun;
  logic              tx_low, rx_high;
  logic [31:0]       ctrl_word, status_word;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
  assign tx_push  = bus_wr && (bus_addr == ADDR_DATA);
  assign rx_pop   = en && bus_rd && (bus_addr == ADDR_DATA);
  assign rx_flush = !en;

  afc_ctrl_reg u_ctrl (
    .clk, .rst_n, .wr(ctrl_wr),
    .wd_en(bus_wdata[0]), .wd_tx_mark(bus_wdata[11:8]), .wd_rx_mark(bus_wdata[15:12]),
    .en, .tx_mark, .rx_mark
  );

  afc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .clr(1'b0), .push(tx_push), .pop(tx_pop),
    .wdata(bus_wdata[DATA_W-1:0]), .head(tx_head), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty)
  );

  afc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .clr(rx_flush), .push(rx_push), .pop(rx_pop),
    .wdata(sample_in), .head(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty)
  );

  afc_link #(.W(DATA_W), .FCNT_W(FCNT_W)) u_link (
    .clk, .rst_n, .en, .strobe(frame_strobe),
    .tx_head, .tx_empty, .rx_full,
    .tx_pop, .rx_push, .rx_drop,
    .sample_out, .frame_sync, .frame_count, .overrun
  );

  assign tx_low  = below_mark(8'(tx_cnt), 8'(tx_mark));
  assign rx_high = reached_mark(8'(rx_cnt), 8'(rx_mark));

  assign dma_tx_req = en && tx_low;
  assign dma_rx_req = en && rx_high;
  assign irq        = en && (tx_low || rx_high || overrun);

  assign ctrl_word = {16'h0, rx_mark, tx_mark, 7'h0, en};

  always_comb begin
    status_word        = '0;
    status_word[7:0]   = 8'(tx_cnt);
    status_word[15:8]  = 8'(rx_cnt);
    status_word[16]    = tx_empty;
    status_word[17]    = tx_full;
    status_word[18]    = tx_low;
    status_word[19]    = rx_empty;
    status_word[20]    = rx_full;
    status_word[21]    = rx_high;
    status_word[22]    = overrun;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:   bus_rdata = ctrl_word;
      ADDR_DATA:   bus_rdata = (en && !rx_empty) ? 32'(rx_head) : 32'h0;
      ADDR_STATUS: bus_rdata = status_word;
      default:     bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/afc_checker.sv
`timescale 1ns/1ps
module afc_checker
  import afc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [1:0]        bus_addr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              tx_push,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic [MARK_W-1:0] tx_mark,
  input logic [MARK_W-1:0] rx_mark,
  input logic              overrun,
  input logic              frame_sync,
  input logic              dma_tx_req,
  input logic              dma_rx_req,
  input logic              irq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH))); // R2
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && en) |=> overrun); // R4
  AST_RX_REQ_AT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (rx_cnt > CW'(rx_mark))) |-> dma_rx_req); // R5
  AST_TX_REQ_BELOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (tx_cnt <= CW'(tx_mark))) |-> dma_tx_req); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!dma_tx_req && !dma_rx_req && !irq)); // R6
  AST_SYNC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(frame_sync)); // R7
  AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_cnt == '0)); // R8
  AST_TX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !tx_push) |=> $stable(tx_cnt)); // R8
  AST_READ_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && bus_rd && (bus_addr == ADDR_DATA)) |-> (bus_rdata == 32'h0)); // R9
endmodule

bind audio_fifo_ctrl afc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tx_push(tx_push), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_mark(tx_mark), .rx_mark(rx_mark), .overrun(overrun), .frame_sync(frame_sync),
  .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
);

// File: tb/tb_audio_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_audio_fifo_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        frame_strobe = 1'b0;
  logic [31:0] sample_in = '0, sample_out;
  logic        frame_sync;
  logic [7:0]  frame_count;
  logic        dma_tx_req, dma_rx_req, irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic exp_sync = 1'b0;
  logic model_en = 1'b0;

  always #10 clk = ~clk;

  audio_fifo_ctrl dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input int txc, input int rxc, input int txm,
                                             input int rxm, input bit ovr);
    logic [31:0] s = '0;
    s[7:0] = 8'(txc); s[15:8] = 8'(rxc);
    s[16] = (txc == 0); s[17] = (txc == 16); s[18] = (txc <= txm);
    s[19] = (rxc == 0); s[20] = (rxc == 16); s[21] = (rxc > rxm);
    s[22] = ovr;
    return s;
  endfunction

  task automatic tick();
    @(negedge clk); @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
    if (a == 2'd0) model_en = d[0];
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic frame(input logic [31:0] v);
    @(negedge clk); frame_strobe = 1'b1; sample_in = v;
    @(posedge clk); #1 frame_strobe = 1'b0;
    if (model_en) exp_sync = ~exp_sync;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(2'd0, d);  check("R1 ctrl reset", d, 32'h0000_7700);
    bus_read(2'd2, d);  check("R10 status reset", d, exp_status(0, 0, 7, 7, 0));
    check("R5 no dma while off", {30'h0, dma_tx_req, dma_rx_req}, 32'h0);
    check("R6 no irq while off", 32'(irq), 32'h0);
    check("R7 sync reset", 32'(frame_sync), 32'h0);
  endtask

  task automatic t_fill_disabled();
    logic [31:0] d;
    for (int i = 0; i < 17; i++) bus_write(2'd1, 32'h1000 + i);
    bus_read(2'd2, d);  check("R2 full, extra write dropped", d, exp_status(16, 0, 7, 7, 0));
    bus_read(2'd1, d);  check("R9 data read zero while off", d, 32'h0);
    bus_read(2'd2, d);  check("R9 read while off removes nothing", d, exp_status(16, 0, 7, 7, 0));
    frame(32'hDEAD);
    check("R8 strobe while off keeps sample_out", sample_out, 32'h0);
    check("R7 sync still while off", 32'(frame_sync), 32'(exp_sync));
  endtask

  task automatic t_enable_frames();
    logic [31:0] d;
    bus_write(2'd0, 32'hFFFF_2301);
    bus_read(2'd0, d);  check("R1 ctrl readback", d, 32'h0000_2301);
    for (int k = 0; k < 3; k++) begin
      frame(32'hA000_0000 + k);
      check("R3 tx word to sample_out", sample_out, 32'h1000 + k);
      check("R7 sync toggles", 32'(frame_sync), 32'(exp_sync));
      if (k == 1) check("R5 rx req off at level 2", 32'(dma_rx_req), 32'h0);
    end
    check("R5 rx req on at level 3", 32'(dma_rx_req), 32'h1);
    check("R6 irq on rx mark", 32'(irq), 32'h1);
    check("R5 tx req off at level 13", 32'(dma_tx_req), 32'h0);
    check("R7 frame count", 32'(frame_count), 32'd3);
    bus_read(2'd1, d);  check("R9 read oldest rx", d, 32'hA000_0000);
    check("R5 rx req off after pop", 32'(dma_rx_req), 32'h0);
  endtask

  task automatic t_drain_overrun();
    logic [31:0] d;
    for (int k = 3; k < 16; k++) begin
      frame(32'hA000_0000 + k);
      check("R3 tx order", sample_out, 32'h1000 + k);
      if (k == 11) check("R5 tx req off at level 4", 32'(dma_tx_req), 32'h0);
      if (k == 12) check("R5 tx req on at level 3", 32'(dma_tx_req), 32'h1);
    end
    frame(32'hB000_0001);
    check("R3 empty tx sends zero", sample_out, 32'h0);
    bus_read(2'd2, d);  check("R10 rx full no overrun", d, exp_status(0, 16, 3, 2, 0));
    frame(32'hB000_0002);
    bus_read(2'd2, d);  check("R4 overrun set", d, exp_status(0, 16, 3, 2, 1));
    bus_read(2'd1, d);  check("R4 dropped sample not stored", d, 32'hA000_0001);
    bus_read(2'd2, d);  check("R4 overrun sticky", d, exp_status(0, 15, 3, 2, 1));
  endtask

  task automatic t_disable();
    logic [31:0] d;
    bus_write(2'd1, 32'h2000);
    bus_write(2'd1, 32'h2001);
    bus_write(2'd0, 32'h0000_2300);
    tick();
    bus_read(2'd2, d);  check("R8 rx flushed, tx kept", d, exp_status(2, 0, 3, 2, 0));
    check("R7 frame count held zero", 32'(frame_count), 32'h0);
    check("R6 irq off when disabled", 32'(irq), 32'h0);
    check("R5 tx req off when disabled", 32'(dma_tx_req), 32'h0);
    frame(32'hC000_0000);
    check("R7 sync held", 32'(frame_sync), 32'(exp_sync));
    bus_read(2'd2, d);  check("R8 tx untouched by strobe", d, exp_status(2, 0, 3, 2, 0));
  endtask

  task automatic t_reenable();
    logic [31:0] d;
    bus_write(2'd0, 32'h0000_2301);
    frame(32'hC000_0001);
    check("R3 kept tx word sent", sample_out, 32'h2000);
    check("R7 sync toggles again", 32'(frame_sync), 32'(exp_sync));
    check("R7 count restarts", 32'(frame_count), 32'd1);
    bus_read(2'd1, d);  check("R9 new rx data", d, 32'hC000_0001);
    bus_read(2'd1, d);  check("R9 empty read zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill_disabled();
    t_enable_frames();
    t_drain_overrun();
    t_disable();
    t_reenable();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule